// File: doc/BRIEF.md
# Snooping Write-Back Data Cache

This block is a direct-mapped data cache of 4 KB placed between a 32-bit load/store port and a shared memory bus. It has 256 lines of 16 bytes. A processor write that hits stays in the cache and marks the line dirty. Memory sees dirty data only when the line is evicted or when another bus master asks for it. Every refill and every eviction moves a whole line as a burst of four 32-bit beats.

The cache also watches the line address of every transaction that another bus master starts. If a foreign read targets a dirty line, the cache holds that master with a stall signal, writes the line back as a burst, and then keeps the line as clean. If a foreign write targets a cached line, the cache drops that line. Addresses in the top 256 MB region (address bits [31:28] equal to 4'hF) are I/O. They are never allocated and never snooped. When the enable input is low, every access bypasses the cache as a single transfer.

The processor holds its request until it sees an acknowledge. A read hit acknowledges in the same cycle as the request. Misses and bypassed accesses acknowledge once the requested word is available.

Top module: `snoop_wb_dcache`

## Requirements
- R1: A read that hits returns the stored word with cpu_ack_o high in the same cycle as the request, and makes no bus request.
- R2: A read miss to an invalid or clean line fetches the line as four burst beats (bus_burst_o high, bus_we_o low). The beats start at the line-aligned address and step by 4. The access then acknowledges with the requested word.
- R3: A write that hits updates only the cached word and marks the line dirty, with no bus activity. A later read of that address returns the new value.
- R4: A miss whose victim line is dirty first writes the victim back as four burst write beats at the victim's own addresses, and only then runs the four-beat refill.
- R5: A snoop read (snp_we_i low) that hits a dirty line raises snp_stall_o until a four-beat write-back burst of that line has finished, and then leaves the line valid and clean. A later eviction of that line performs no write-back.
- R6: A snoop write (snp_we_i high) that hits a cached line is accepted without stall and invalidates the line, so the next processor read of it misses.
- R7: A snoop that misses, or that hits a clean line with snp_we_i low, causes no stall and no bus activity.
- R8: An access with address bits [31:28] equal to 4'hF is done as one non-burst bus transfer and is never allocated, so repeating it goes to the bus again.
- R9: With cache_en_i low, every access (including one to an address held in the cache) is one non-burst bus transfer.
- R10: During and right after reset, cpu_ack_o, bus_req_o and snp_stall_o are low and every line is invalid.
- R11: While bus_req_o is high and bus_rdy_i is low, bus_req_o, bus_addr_o and bus_we_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | Cache enable; low bypasses the cache |
| cpu_req_i | input | 1 | Processor access request, held until acknowledge |
| cpu_we_i | input | 1 | Processor access is a write |
| cpu_addr_i | input | 32 | Processor byte address (word aligned) |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_ack_o | output | 1 | Access complete |
| cpu_rdata_o | output | 32 | Read data, valid with acknowledge |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | Bus beat is a write |
| bus_burst_o | output | 1 | Beat belongs to a four-beat line burst |
| bus_addr_o | output | 32 | Bus beat address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, taken with ready |
| bus_rdy_i | input | 1 | Beat completes at this edge |
| snp_valid_i | input | 1 | Another master is accessing the bus |
| snp_we_i | input | 1 | The foreign access is a write |
| snp_line_i | input | 28 | Line address (byte address bits [31:4]) of the foreign access |
| snp_stall_o | output | 1 | Holds the foreign master while the cache acts |

## Verification
The processor side is driven through a table of mixed patterns, and the bus beats each access causes are counted. The patterns are a cold read, a read of a neighbouring word, a write hit followed by a read-back, a conflicting address that evicts a dirty victim, a re-read of the evicted data, and repeated I/O reads and writes. Together they separate a hit from a clean miss and from a dirty eviction, and they show whether written data really survives the write-back. Directed cases then check the order and data of the eviction beats. They also run snoop reads to dirty, clean and absent lines, which tells a flush apart from a harmless look-up, and a snoop write that must force a later miss. A last group disables the cache to show that a line already held is bypassed.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;                 // words per line
  localparam int WORD_W = $clog2(WORDS);
  localparam int OFF_W  = WORD_W + 2;        // byte offset inside a line
  localparam int LINE_W = ADDR_W - OFF_W;    // line address width

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_SINGLE,
    ST_RESP
  } dc_state_e;
endpackage

// File: rtl/dc_tag_ram.sv
module dc_tag_ram
  import dcache_pkg::*;
#(
  parameter int LINES = 256,
  parameter int IDX_W = $clog2(LINES),
  parameter int TAG_W = LINE_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [TAG_W-1:0] a_tag_o,
  output logic             a_valid_o,
  output logic             a_dirty_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [TAG_W-1:0] b_tag_o,
  output logic             b_valid_o,
  output logic             b_dirty_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             dset_en_i,
  input  logic [IDX_W-1:0] dset_idx_i,
  input  logic             dclr_en_i,
  input  logic [IDX_W-1:0] dclr_idx_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_idx_i] <= fill_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en_i) begin
        valid_q[fill_idx_i] <= 1'b1;
        dirty_q[fill_idx_i] <= 1'b0;
      end
      if (inv_en_i) begin
        valid_q[inv_idx_i] <= 1'b0;
        dirty_q[inv_idx_i] <= 1'b0;
      end
      if (dset_en_i) dirty_q[dset_idx_i] <= 1'b1;
      if (dclr_en_i) dirty_q[dclr_idx_i] <= 1'b0;
    end
  end

  assign a_tag_o   = tag_q[a_idx_i];
  assign a_valid_o = valid_q[a_idx_i];
  assign a_dirty_o = dirty_q[a_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_valid_o = valid_q[b_idx_i];
  assign b_dirty_o = dirty_q[b_idx_i];

  a_r6_inval_drops_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i |=> !valid_q[$past(inv_idx_i)]);

  a_r5_flush_leaves_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclr_en_i |=> valid_q[$past(dclr_idx_i)] && !dirty_q[$past(dclr_idx_i)]);

  a_r2_fill_valid_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> valid_q[$past(fill_idx_i)] && !dirty_q[$past(fill_idx_i)]);
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram
  import dcache_pkg::*;
#(
  parameter int LINES = 256,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [WORD_W-1:0] ra_word_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic [WORD_W-1:0] rb_word_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [WORD_W-1:0] w_word_i,
  input  logic [DATA_W-1:0] w_data_i
);
  logic [DATA_W-1:0] mem_q [LINES][WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[w_idx_i][w_word_i] <= w_data_i;
  end

  assign ra_data_o = mem_q[ra_idx_i][ra_word_i];
  assign rb_data_o = mem_q[rb_idx_i][rb_word_i];

  a_r3_word_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(w_idx_i)][$past(w_word_i)] == $past(w_data_i));
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dcache_pkg::*;
#(
  parameter int         LINES  = 256,
  parameter logic [3:0] IO_NIB = 4'hF,
  parameter int         IDX_W  = $clog2(LINES),
  parameter int         TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_en_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_burst_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              snp_stall_o,
  // tag store
  output logic [IDX_W-1:0]  a_idx_o,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic              a_valid_i,
  input  logic              a_dirty_i,
  output logic [IDX_W-1:0]  b_idx_o,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic              b_valid_i,
  input  logic              b_dirty_i,
  output logic              fill_en_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic              dset_en_o,
  output logic [IDX_W-1:0]  dset_idx_o,
  output logic              dclr_en_o,
  output logic [IDX_W-1:0]  dclr_idx_o,
  output logic              inv_en_o,
  output logic [IDX_W-1:0]  inv_idx_o,
  // data store
  output logic [IDX_W-1:0]  ra_idx_o,
  output logic [WORD_W-1:0] ra_word_o,
  input  logic [DATA_W-1:0] ra_data_i,
  output logic [IDX_W-1:0]  rb_idx_o,
  output logic [WORD_W-1:0] rb_word_o,
  input  logic [DATA_W-1:0] rb_data_i,
  output logic              dw_en_o,
  output logic [IDX_W-1:0]  dw_idx_o,
  output logic [WORD_W-1:0] dw_word_o,
  output logic [DATA_W-1:0] dw_data_o
);
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

  dc_state_e         state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  wb_idx_q, wb_idx_d;
  logic [TAG_W-1:0]  wb_tag_q, wb_tag_d;
  logic              wb_snp_q, wb_snp_d;
  logic [DATA_W-1:0] single_q;

  // processor address fields
  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WORD_W-1:0] cpu_word;
  logic              cpu_io, cacheable, cpu_hit;
  assign cpu_tag   = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx   = cpu_addr_i[OFF_W +: IDX_W];
  assign cpu_word  = cpu_addr_i[2 +: WORD_W];
  assign cpu_io    = (cpu_addr_i[ADDR_W-1 -: 4] == IO_NIB);
  assign cacheable = cache_en_i && !cpu_io;
  assign cpu_hit   = a_valid_i && (a_tag_i == cpu_tag);

  // snoop address fields
  logic [TAG_W-1:0] snp_tag;
  logic             snp_io, snp_hit, snp_flush, snp_inval, snp_act, idle, cpu_go;
  assign snp_tag   = snp_line_i[LINE_W-1 -: TAG_W];
  assign snp_io    = (snp_line_i[LINE_W-1 -: 4] == IO_NIB);
  assign snp_hit   = snp_valid_i && !snp_io && b_valid_i && (b_tag_i == snp_tag);
  assign idle      = (state_q == ST_IDLE);
  assign snp_flush = idle && snp_hit && !snp_we_i && b_dirty_i;
  assign snp_inval = idle && snp_hit && snp_we_i;
  assign snp_act   = snp_flush || snp_inval;
  assign cpu_go    = idle && cpu_req_i && !snp_act;

  assign a_idx_o   = cpu_idx;
  assign b_idx_o   = snp_line_i[IDX_W-1:0];
  assign ra_idx_o  = cpu_idx;
  assign ra_word_o = cpu_word;
  assign rb_idx_o  = wb_idx_q;
  assign rb_word_o = beat_q;

  // foreign master waits whenever this cache owns the bus or must flush
  assign snp_stall_o = snp_valid_i && (!idle || (snp_hit && !snp_we_i && b_dirty_i));

  assign cpu_ack_o   = (cpu_go && cacheable && cpu_hit) || (state_q == ST_RESP);
  assign cpu_rdata_o = (state_q == ST_RESP) ? single_q : ra_data_i;

  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    wb_idx_d   = wb_idx_q;
    wb_tag_d   = wb_tag_q;
    wb_snp_d   = wb_snp_q;
    bus_req_o  = 1'b0;
    bus_we_o   = 1'b0;
    bus_burst_o = 1'b0;
    bus_addr_o = '0;
    bus_wdata_o = '0;
    fill_en_o  = 1'b0;
    fill_idx_o = cpu_idx;
    fill_tag_o = cpu_tag;
    dset_en_o  = 1'b0;
    dset_idx_o = cpu_idx;
    dclr_en_o  = 1'b0;
    dclr_idx_o = wb_idx_q;
    inv_en_o   = snp_inval;
    inv_idx_o  = snp_line_i[IDX_W-1:0];
    dw_en_o    = 1'b0;
    dw_idx_o   = cpu_idx;
    dw_word_o  = cpu_word;
    dw_data_o  = cpu_wdata_i;

    unique case (state_q)
      ST_IDLE: begin
        if (snp_flush) begin
          wb_idx_d = snp_line_i[IDX_W-1:0];
          wb_tag_d = snp_tag;
          wb_snp_d = 1'b1;
          beat_d   = '0;
          state_d  = ST_WB;
        end else if (cpu_go) begin
          if (!cacheable) begin
            state_d = ST_SINGLE;
          end else if (cpu_hit) begin
            if (cpu_we_i) begin
              dw_en_o   = 1'b1;
              dset_en_o = 1'b1;
            end
          end else if (a_valid_i && a_dirty_i) begin
            wb_idx_d = cpu_idx;
            wb_tag_d = a_tag_i;
            wb_snp_d = 1'b0;
            beat_d   = '0;
            state_d  = ST_WB;
          end else begin
            beat_d  = '0;
            state_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_burst_o = 1'b1;
        bus_addr_o  = {wb_tag_q, wb_idx_q, beat_q, 2'b00};
        bus_wdata_o = rb_data_i;
        if (bus_rdy_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            if (wb_snp_q) begin
              dclr_en_o = 1'b1;
              state_d   = ST_IDLE;
            end else begin
              state_d = ST_FILL;
            end
          end
        end
      end
      ST_FILL: begin
        bus_req_o   = 1'b1;
        bus_burst_o = 1'b1;
        bus_addr_o  = {cpu_tag, cpu_idx, beat_q, 2'b00};
        if (bus_rdy_i) begin
          dw_en_o   = 1'b1;
          dw_word_o = beat_q;
          dw_data_o = bus_rdata_i;
          beat_d    = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            fill_en_o = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_SINGLE: begin
        bus_req_o   = 1'b1;
        bus_we_o    = cpu_we_i;
        bus_addr_o  = cpu_addr_i;
        bus_wdata_o = cpu_wdata_i;
        if (bus_rdy_i) state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      wb_idx_q <= '0;
      wb_tag_q <= '0;
      wb_snp_q <= 1'b0;
      single_q <= '0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      wb_idx_q <= wb_idx_d;
      wb_tag_q <= wb_tag_d;
      wb_snp_q <= wb_snp_d;
      if (state_q == ST_SINGLE && bus_rdy_i) single_q <= bus_rdata_i;
    end
  end

  a_r11_beat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_rdy_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  a_r2_burst_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && bus_burst_o |-> bus_addr_o[OFF_W-1:0] == '0);

  a_r1_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i);

  a_r4_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WB && !wb_snp_q && bus_rdy_i && beat_q == LAST_BEAT |=> bus_req_o && bus_burst_o && !bus_we_o);

  a_r8_single_not_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_burst_o && bus_rdy_i |=> cpu_ack_o);
endmodule

// File: rtl/snoop_wb_dcache.sv
module snoop_wb_dcache
  import dcache_pkg::*;
#(
  parameter int         LINES  = 256,
  parameter logic [3:0] IO_NIB = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_en_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_burst_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              snp_stall_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LINE_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx, fill_idx, dset_idx, dclr_idx, inv_idx;
  logic [TAG_W-1:0]  a_tag, b_tag, fill_tag;
  logic              a_valid, a_dirty, b_valid, b_dirty;
  logic              fill_en, dset_en, dclr_en, inv_en;
  logic [IDX_W-1:0]  ra_idx, rb_idx, dw_idx;
  logic [WORD_W-1:0] ra_word, rb_word, dw_word;
  logic [DATA_W-1:0] ra_data, rb_data, dw_data;
  logic              dw_en;

  dc_tag_ram #(.LINES(LINES)) u_tags (
    .clk_i, .rst_ni,
    .a_idx_i(a_idx), .a_tag_o(a_tag), .a_valid_o(a_valid), .a_dirty_o(a_dirty),
    .b_idx_i(b_idx), .b_tag_o(b_tag), .b_valid_o(b_valid), .b_dirty_o(b_dirty),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
    .dset_en_i(dset_en), .dset_idx_i(dset_idx),
    .dclr_en_i(dclr_en), .dclr_idx_i(dclr_idx),
    .inv_en_i(inv_en), .inv_idx_i(inv_idx)
  );

  dc_data_ram #(.LINES(LINES)) u_data (
    .clk_i, .rst_ni,
    .ra_idx_i(ra_idx), .ra_word_i(ra_word), .ra_data_o(ra_data),
    .rb_idx_i(rb_idx), .rb_word_i(rb_word), .rb_data_o(rb_data),
    .we_i(dw_en), .w_idx_i(dw_idx), .w_word_i(dw_word), .w_data_i(dw_data)
  );

  dc_ctrl #(.LINES(LINES), .IO_NIB(IO_NIB)) u_ctrl (
    .clk_i, .rst_ni, .cache_en_i,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_ack_o, .cpu_rdata_o,
    .bus_req_o, .bus_we_o, .bus_burst_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i, .bus_rdy_i,
    .snp_valid_i, .snp_we_i, .snp_line_i, .snp_stall_o,
    .a_idx_o(a_idx), .a_tag_i(a_tag), .a_valid_i(a_valid), .a_dirty_i(a_dirty),
    .b_idx_o(b_idx), .b_tag_i(b_tag), .b_valid_i(b_valid), .b_dirty_i(b_dirty),
    .fill_en_o(fill_en), .fill_idx_o(fill_idx), .fill_tag_o(fill_tag),
    .dset_en_o(dset_en), .dset_idx_o(dset_idx),
    .dclr_en_o(dclr_en), .dclr_idx_o(dclr_idx),
    .inv_en_o(inv_en), .inv_idx_o(inv_idx),
    .ra_idx_o(ra_idx), .ra_word_o(ra_word), .ra_data_i(ra_data),
    .rb_idx_o(rb_idx), .rb_word_o(rb_word), .rb_data_i(rb_data),
    .dw_en_o(dw_en), .dw_idx_o(dw_idx), .dw_word_o(dw_word), .dw_data_o(dw_data)
  );

  a_r10_quiet_after_reset: assert property (@(posedge clk_i)
    !rst_ni |=> !cpu_ack_o && !bus_req_o);
endmodule

// File: tb/snoop_wb_dcache_bench.sv
module snoop_wb_dcache_bench;
  localparam int CLK_T = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cache_en_i;
  logic        cpu_req_i, cpu_we_i;
  logic [31:0] cpu_addr_i, cpu_wdata_i;
  logic        cpu_ack_o;
  logic [31:0] cpu_rdata_o;
  logic        bus_req_o, bus_we_o, bus_burst_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [31:0] bus_rdata_i;
  logic        bus_rdy_i;
  logic        snp_valid_i, snp_we_i;
  logic [27:0] snp_line_i;
  logic        snp_stall_o;

  always #(CLK_T/2) clk_i = ~clk_i;

  snoop_wb_dcache u_snoop_wb_dcache (.*);

  int total = 0;
  int bad = 0;

  // bus memory model and beat log
  logic [31:0] bmem [1024];
  logic [31:0] log_addr [64];
  logic [31:0] log_wdata [64];
  logic        log_we [64];
  logic        log_burst [64];
  int          log_n = 0;
  logic        wtog = 1'b0;

  function automatic int hsh(input logic [31:0] a);
    return int'({22'd0, a[15:12], a[7:2]});
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'hC0DE0000 | i;
    bus_rdy_i = 1'b0;
    bus_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      bus_rdy_i = 1'b0;
      if (bus_req_o) begin
        if (wtog) begin
          bus_rdy_i = 1'b1;
          bus_rdata_i = bmem[hsh(bus_addr_o)];
          if (bus_we_o) bmem[hsh(bus_addr_o)] = bus_wdata_o;
          if (log_n < 64) begin
            log_addr[log_n]  = bus_addr_o;
            log_wdata[log_n] = bus_wdata_o;
            log_we[log_n]    = bus_we_o;
            log_burst[log_n] = bus_burst_o;
            log_n++;
          end
        end
        wtog = !wtog;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int beats);
    @(posedge clk_i); #1;
    log_n = 0;
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
    forever begin
      @(negedge clk_i);
      if (cpu_ack_o) begin
        rd = cpu_rdata_o;
        break;
      end
    end
    @(posedge clk_i); #1;
    cpu_req_i = 1'b0;
    beats = log_n;
  endtask

  task automatic snoop(input logic we, input logic [27:0] line, output logic stall0, output int beats);
    @(posedge clk_i); #1;
    log_n = 0;
    snp_valid_i = 1'b1; snp_we_i = we; snp_line_i = line;
    @(negedge clk_i);
    stall0 = snp_stall_o;
    while (snp_stall_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    snp_valid_i = 1'b0;
    @(negedge clk_i);
    beats = log_n;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  beats;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b0, 32'h0000_0040, 32'h0,          32'hC0DE_0010, 4'd4, 4'd2},
    '{1'b0, 32'h0000_0044, 32'h0,          32'hC0DE_0011, 4'd0, 4'd1},
    '{1'b1, 32'h0000_0048, 32'h1111_2222,  32'h0,         4'd0, 4'd3},
    '{1'b0, 32'h0000_0048, 32'h0,          32'h1111_2222, 4'd0, 4'd3},
    '{1'b0, 32'h0000_1040, 32'h0,          32'hC0DE_0050, 4'd8, 4'd4},
    '{1'b0, 32'h0000_0048, 32'h0,          32'h1111_2222, 4'd4, 4'd4},
    '{1'b0, 32'hF000_8080, 32'h0,          32'hC0DE_0220, 4'd1, 4'd8},
    '{1'b0, 32'hF000_8080, 32'h0,          32'hC0DE_0220, 4'd1, 4'd8},
    '{1'b1, 32'hF000_8084, 32'h5A5A_0001,  32'h0,         4'd1, 4'd8},
    '{1'b0, 32'hF000_8084, 32'h0,          32'h5A5A_0001, 4'd1, 4'd8}
  };

  initial begin
    #(CLK_T * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          nb;
    logic        st;
    rst_ni = 1'b0;
    cache_en_i = 1'b1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0; cpu_addr_i = '0; cpu_wdata_i = '0;
    snp_valid_i = 1'b0; snp_we_i = 1'b0; snp_line_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!cpu_ack_o && !bus_req_o && !snp_stall_o, "R10 outputs in reset", {29'd0, cpu_ack_o, bus_req_o, snp_stall_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cpu_ack_o && !bus_req_o && !snp_stall_o, "R10 outputs after reset", {29'd0, cpu_ack_o, bus_req_o, snp_stall_o}, 32'd0);

    // table walk: R1 R2 R3 R4 R8 (req column names the requirement)
    foreach (TBL[k]) begin
      cpu_op(TBL[k].we, TBL[k].addr, TBL[k].wdata, rd, nb);
      if (!TBL[k].we)
        chk(rd == TBL[k].exp, $sformatf("R%0d row %0d data", TBL[k].req, k), rd, TBL[k].exp);
      chk(nb == int'(TBL[k].beats), $sformatf("R%0d row %0d beats", TBL[k].req, k), nb, {28'd0, TBL[k].beats});
      if (k == 0) begin
        chk(log_addr[0] == 32'h40 && log_addr[3] == 32'h4C && log_burst[0] && !log_we[0], "R2 fill order", log_addr[3], 32'h4C);
      end
      if (k == 6) chk(!log_burst[0], "R8 io not burst", {31'd0, log_burst[0]}, 32'd0);
    end

    // R4: eviction order and data
    cpu_op(1'b1, 32'h0000_0204, 32'hD00D_0001, rd, nb);
    chk(nb == 4, "R4 write-allocate fill", nb, 4);
    cpu_op(1'b0, 32'h0000_1200, 32'h0, rd, nb);
    chk(nb == 8, "R4 evict beats", nb, 8);
    chk(log_we[0] && log_addr[0] == 32'h200 && log_burst[0], "R4 first wb beat", log_addr[0], 32'h200);
    chk(log_addr[1] == 32'h204 && log_wdata[1] == 32'hD00D_0001, "R4 wb dirty word", log_wdata[1], 32'hD00D_0001);
    chk(log_we[3] && log_addr[3] == 32'h20C, "R4 last wb beat", log_addr[3], 32'h20C);
    chk(!log_we[4] && log_addr[4] == 32'h1200, "R4 fill after wb", log_addr[4], 32'h1200);
    chk(rd == 32'hC0DE_0040, "R4 refill data", rd, 32'hC0DE_0040);

    // R5: snoop read of dirty line
    cpu_op(1'b1, 32'h0000_1204, 32'hBEEF_0001, rd, nb);
    chk(nb == 0, "R3 write hit no bus", nb, 0);
    snoop(1'b0, 28'h000_0120, st, nb);
    chk(st, "R5 stall on dirty snoop", {31'd0, st}, 32'd1);
    chk(nb == 4 && log_we[0] && log_addr[0] == 32'h1200, "R5 flush burst", nb, 4);
    chk(log_wdata[1] == 32'hBEEF_0001, "R5 flushed data", log_wdata[1], 32'hBEEF_0001);
    snoop(1'b0, 28'h000_0120, st, nb);
    chk(!st && nb == 0, "R7 clean hit snoop quiet", {31'd0, st}, 32'd0);
    cpu_op(1'b0, 32'h0000_0200, 32'h0, rd, nb);
    chk(nb == 4 && !log_we[0], "R5 clean after flush, no wb", nb, 4);
    chk(rd == 32'hC0DE_0000, "R5 refill data", rd, 32'hC0DE_0000);

    // R6: snoop write invalidates
    snoop(1'b1, 28'h000_0020, st, nb);
    chk(!st && nb == 0, "R6 snoop write no stall", {31'd0, st}, 32'd0);
    cpu_op(1'b0, 32'h0000_0204, 32'h0, rd, nb);
    chk(nb == 4, "R6 line dropped forces miss", nb, 4);
    chk(rd == 32'hD00D_0001, "R6 refetched data", rd, 32'hD00D_0001);

    // R7: snoop miss
    snoop(1'b0, 28'h000_0300, st, nb);
    chk(!st && nb == 0, "R7 snoop miss quiet", nb, 0);

    // R9: cache disabled
    cache_en_i = 1'b0;
    cpu_op(1'b0, 32'h0000_0204, 32'h0, rd, nb);
    chk(nb == 1 && !log_burst[0], "R9 bypass held line", nb, 1);
    chk(rd == 32'hD00D_0001, "R9 bypass data", rd, 32'hD00D_0001);
    cpu_op(1'b1, 32'h0000_0208, 32'h7777_0000, rd, nb);
    chk(nb == 1 && log_we[0] && log_addr[0] == 32'h208, "R9 bypass write", log_addr[0], 32'h208);
    cpu_op(1'b0, 32'h0000_0208, 32'h0, rd, nb);
    chk(rd == 32'h7777_0000 && nb == 1, "R9 bypass read back", rd, 32'h7777_0000);
    cache_en_i = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule